// File: doc/BRIEF.md
# Planar Video Memory Write Steering

This block sits between a CPU byte-write port and four byte-wide video memory planes. For every CPU write it decides which planes get a write strobe and at which offset inside each plane the byte lands. One CPU write can fill one plane, a subset of planes or all four planes in the same clock. Filling all four at once is what makes bulk clears and solid fills four times faster than a byte-at-a-time loop.

Two programmable settings drive the decision. The first is a four-bit plane enable mask. The second is an addressing mode register with two flags, chain-4 and odd/even, which remap the CPU address onto a plane select and a plane offset. Software sets both through an index/data pair: a write to the index port selects a register, and a later write to the data port loads that register. The strobes, the offset and the data byte leave the block together from one set of output registers, one clock after the CPU write is accepted.

Top module: `planar_write_steer`

## Requirements
- R1: After reset the plane enable mask is 4'b1111 and both mode flags are clear, so the first CPU write goes to all four planes at an offset equal to the CPU address. No strobe is active while reset is held or just after it.
- R2: A config write with the index-select input high stores cfgData as the current index and changes no setting. A config write with the index-select input low loads the register the stored index names. Index 8'h02 loads the plane mask from cfgData[3:0] and ignores bits 7..4. Any index other than 8'h02 and 8'h04 has no effect.
- R3: Index 8'h04 loads the mode flags: cfgData[3] is chain-4 and cfgData[2] is odd/even. All other bits are ignored.
- R4: With both flags clear (planar), a CPU write strobes every plane whose mask bit is set. The offset is the full CPU address and the same byte goes to each strobed plane.
- R5: With chain-4 set, the strobed plane is the one numbered by cpuAddr[1:0], gated by its mask bit, and the offset is cpuAddr shifted right by two. Chain-4 takes priority over odd/even when both are set.
- R6: With chain-4 clear and odd/even set, an even address selects planes 0 and 2 and an odd address selects planes 1 and 3, each gated by the mask. The offset is cpuAddr with bit 0 forced to 0.
- R7: The strobes, offset and data for a write accepted at one rising edge appear together after that edge and last one cycle. Back-to-back writes produce back-to-back strobes. A cycle without a CPU write leaves all strobes low.
- R8: When a config data write and a CPU write fall in the same cycle, the CPU write is steered by the settings that were in force before that cycle. The new setting applies from the next CPU write on.
- R9: A CPU write whose selected planes all have clear mask bits strobes no plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config port write strobe |
| cfgSelIndex | input | 1 | 1: write goes to the index port, 0: write goes to the data port |
| cfgData | input | CFG_W | Config write byte |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuAddr | input | ADDR_W | CPU byte address |
| cpuData | input | DATA_W | CPU write byte |
| planeWe | output | 4 | Per-plane write strobe, bit n for plane n |
| planeAddr | output | ADDR_W | Offset within each strobed plane |
| planeData | output | DATA_W | Byte written to each strobed plane |

## Verification
Two functions can coincide: a config data write that changes the mask or mode flags, and a CPU write that those very settings steer. The bench selects the target register with an index write and then asserts the data write and a CPU write on the same edge. It checks that the strobes and offset follow the old setting, and that the next CPU write follows the new one. A behavioural model applies the same ordering and is compared with the outputs every cycle. The bench also checks back-to-back CPU writes, where one write's outputs and the next write's acceptance share an edge.

// File: rtl/planar_steer_pkg.sv
package planar_steer_pkg;

  localparam int NUM_PLANES = 4;
  localparam int SEL_W      = $clog2(NUM_PLANES);

  typedef enum logic [1:0] {
    MAP_PLANAR  = 2'd0,
    MAP_ODDEVEN = 2'd1,
    MAP_CHAIN4  = 2'd2
  } mapMode_e;

  // strobes handed from control to datapath for one CPU write
  typedef struct packed {
    logic                  issue;
    logic [NUM_PLANES-1:0] planeEn;
    mapMode_e              mode;
  } steerCtl_t;

endpackage

// File: rtl/planar_steer_ctrl.sv
module planar_steer_ctrl
  import planar_steer_pkg::*;
#(
  parameter int             CFG_W       = 8,
  parameter logic [CFG_W-1:0] MASK_IDX  = 8'h02,
  parameter logic [CFG_W-1:0] MODE_IDX  = 8'h04,
  parameter int             CHAIN4_BIT  = 3,
  parameter int             ODDEVEN_BIT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic                  cfgSelIndex,
  input  logic [CFG_W-1:0]      cfgData,
  input  logic                  cpuWrEn,
  input  logic [SEL_W-1:0]      addrLow,
  output steerCtl_t             ctl,
  output logic [NUM_PLANES-1:0] curMask,
  output logic                  curChain4,
  output logic                  curOddEven
);

  localparam logic [NUM_PLANES-1:0] MASK_RST = '1;

  logic [CFG_W-1:0]      idxReg;
  logic [NUM_PLANES-1:0] maskReg;
  logic                  chain4Reg;
  logic                  oddEvenReg;

  logic                  dataWr;
  logic                  maskLoad;
  logic                  modeLoad;

  assign dataWr   = cfgWrEn && !cfgSelIndex;
  assign maskLoad = dataWr && (idxReg == MASK_IDX);
  assign modeLoad = dataWr && (idxReg == MODE_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
    end else if (cfgWrEn && cfgSelIndex) begin
      idxReg <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= MASK_RST;
    end else if (maskLoad) begin
      maskReg <= cfgData[NUM_PLANES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain4Reg  <= 1'b0;
      oddEvenReg <= 1'b0;
    end else if (modeLoad) begin
      chain4Reg  <= cfgData[CHAIN4_BIT];
      oddEvenReg <= cfgData[ODDEVEN_BIT];
    end
  end

  // per-plane select decode for each addressing variant
  logic [NUM_PLANES-1:0] chainSel;
  logic [NUM_PLANES-1:0] pairSel;
  logic [NUM_PLANES-1:0] planarSel;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_sel
    assign chainSel[p]  = (addrLow == SEL_W'(p));
    assign pairSel[p]   = (addrLow[0] == ((p % 2) == 1));
    assign planarSel[p] = 1'b1;
  end

  mapMode_e              modeNow;
  logic [NUM_PLANES-1:0] selNow;

  always_comb begin
    if (chain4Reg) begin
      modeNow = MAP_CHAIN4;
    end else if (oddEvenReg) begin
      modeNow = MAP_ODDEVEN;
    end else begin
      modeNow = MAP_PLANAR;
    end
  end

  always_comb begin
    unique case (modeNow)
      MAP_CHAIN4:  selNow = chainSel;
      MAP_ODDEVEN: selNow = pairSel;
      default:     selNow = planarSel;
    endcase
  end

  always_comb begin
    ctl.issue   = cpuWrEn;
    ctl.planeEn = maskReg & selNow;
    ctl.mode    = modeNow;
  end

  assign curMask    = maskReg;
  assign curChain4  = chain4Reg;
  assign curOddEven = oddEvenReg;

endmodule

// File: rtl/planar_steer_dp.sv
module planar_steer_dp
  import planar_steer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  steerCtl_t             ctl,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuData,
  output logic [NUM_PLANES-1:0] planeWe,
  output logic [ADDR_W-1:0]     planeAddr,
  output logic [DATA_W-1:0]     planeData
);

  logic [ADDR_W-1:0] offsetNow;

  always_comb begin
    unique case (ctl.mode)
      MAP_CHAIN4:  offsetNow = cpuAddr >> SEL_W;
      MAP_ODDEVEN: offsetNow = {cpuAddr[ADDR_W-1:1], 1'b0};
      default:     offsetNow = cpuAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeWe <= '0;
    end else begin
      planeWe <= ctl.issue ? ctl.planeEn : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeAddr <= '0;
      planeData <= '0;
    end else if (ctl.issue) begin
      planeAddr <= offsetNow;
      planeData <= cpuData;
    end
  end

endmodule

// File: rtl/planar_write_steer.sv
module planar_write_steer
  import planar_steer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSelIndex,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output logic [3:0]        planeWe,
  output logic [ADDR_W-1:0] planeAddr,
  output logic [DATA_W-1:0] planeData
);

  steerCtl_t             ctl;
  logic [NUM_PLANES-1:0] curMask;
  logic                  curChain4;
  logic                  curOddEven;

  planar_steer_ctrl #(
    .CFG_W (CFG_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSelIndex(cfgSelIndex),
    .cfgData    (cfgData),
    .cpuWrEn    (cpuWrEn),
    .addrLow    (cpuAddr[SEL_W-1:0]),
    .ctl        (ctl),
    .curMask    (curMask),
    .curChain4  (curChain4),
    .curOddEven (curOddEven)
  );

  planar_steer_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cpuAddr  (cpuAddr),
    .cpuData  (cpuData),
    .planeWe  (planeWe),
    .planeAddr(planeAddr),
    .planeData(planeData)
  );

endmodule

// File: rtl/planar_write_steer_chk.sv
module planar_write_steer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWrEn,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuData,
  input logic [3:0]        planeWe,
  input logic [ADDR_W-1:0] planeAddr,
  input logic [DATA_W-1:0] planeData,
  input logic [3:0]        curMask,
  input logic              curChain4,
  input logic              curOddEven
);

  // R7
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWrEn |=> (planeWe == 4'b0000));

  // R7
  data_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> (planeData == $past(cpuData)));

  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> ((planeWe & ~$past(curMask)) == 4'b0000));

  // R4
  planar_fanout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !curChain4 && !curOddEven) |=>
      (planeWe == $past(curMask)) && (planeAddr == $past(cpuAddr)));

  // R5
  chain4_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && curChain4) |=>
      ($countones(planeWe) <= 1) && (planeAddr == ($past(cpuAddr) >> 2)));

  // R6
  oddeven_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !curChain4 && curOddEven) |=>
      (planeAddr[0] == 1'b0) &&
      ((planeWe & ($past(cpuAddr[0]) ? 4'b0101 : 4'b1010)) == 4'b0000));

endmodule

bind planar_write_steer planar_write_steer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuWrEn   (cpuWrEn),
  .cpuAddr   (cpuAddr),
  .cpuData   (cpuData),
  .planeWe   (planeWe),
  .planeAddr (planeAddr),
  .planeData (planeData),
  .curMask   (curMask),
  .curChain4 (curChain4),
  .curOddEven(curOddEven)
);

// File: tb/planar_write_steer_tb.sv
module planar_write_steer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int CFG_W      = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgSelIndex = 1'b0;
  logic [CFG_W-1:0]  cfgData = '0;
  logic              cpuWrEn = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuData = '0;
  logic [3:0]        planeWe;
  logic [ADDR_W-1:0] planeAddr;
  logic [DATA_W-1:0] planeData;

  always #(CLK_PERIOD/2) clk = ~clk;

  planar_write_steer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSelIndex(cfgSelIndex),
    .cfgData(cfgData), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .planeWe(planeWe), .planeAddr(planeAddr),
    .planeData(planeData)
  );

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mIdx, mMask, mChain, mOdd;
  int expWe, expAddr, expData;
  bit modelLive = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mMask = 15; mChain = 0; mOdd = 0;
      expWe = 0; expAddr = 0; expData = 0;
    end else begin
      int a;
      a = int'(cpuAddr);
      if (cpuWrEn) begin
        if (mChain != 0) begin
          expWe = mMask & (1 << (a % 4));
          expAddr = a / 4;
        end else if (mOdd != 0) begin
          expWe = mMask & (((a % 2) == 1) ? 10 : 5);
          expAddr = a - (a % 2);
        end else begin
          expWe = mMask;
          expAddr = a;
        end
        expData = int'(cpuData);
      end else begin
        expWe = 0;
      end
      if (cfgWrEn) begin
        if (cfgSelIndex) mIdx = int'(cfgData);
        else if (mIdx == 2) mMask = int'(cfgData) % 16;
        else if (mIdx == 4) begin
          mChain = (int'(cfgData) >> 3) % 2;
          mOdd   = (int'(cfgData) >> 2) % 2;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (modelLive) begin
      chk(curReq, "planeWe", int'(planeWe), expWe);
      if (expWe != 0) begin
        chk(curReq, "planeAddr", int'(planeAddr), expAddr);
        chk(curReq, "planeData", int'(planeData), expData);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cfgWrEn = 1'b0; cpuWrEn = 1'b0;
  endtask

  task automatic cfgWrite(int idx, int val);
    @(negedge clk);
    cpuWrEn = 1'b0;
    cfgWrEn = 1'b1; cfgSelIndex = 1'b1; cfgData = CFG_W'(idx);
    @(negedge clk);
    cfgSelIndex = 1'b0; cfgData = CFG_W'(val);
    idle();
  endtask

  task automatic cpuWrite(int addr, int data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    cpuWrEn = 1'b1; cpuAddr = ADDR_W'(addr); cpuData = DATA_W'(data);
  endtask

  // directed check of the outputs one cycle after a single write
  task automatic writeAndExpect(string req, int addr, int data, int we, int off);
    cpuWrite(addr, data);
    idle();
    chk(req, "directed planeWe", int'(planeWe), we);
    if (we != 0) chk(req, "directed planeAddr", int'(planeAddr), off);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "planeWe in reset", int'(planeWe), 0);
    rstN = 1'b1;
    modelLive = 1;
    idle();
    chk("R1", "planeWe after reset", int'(planeWe), 0);

    curReq = "R1";
    writeAndExpect("R1", 16'h1234, 8'h5A, 4'hF, 16'h1234);

    curReq = "R4";
    cfgWrite(2, 8'h05);
    writeAndExpect("R4", 16'h0101, 8'h11, 4'h5, 16'h0101);

    curReq = "R2";
    cfgWrite(3, 8'hFF);
    cfgWrite(1, 8'h08);
    writeAndExpect("R2", 16'h0102, 8'h22, 4'h5, 16'h0102);
    cfgWrite(2, 8'hF3);
    writeAndExpect("R2", 16'h0203, 8'h33, 4'h3, 16'h0203);
    // index-port write carrying a mode-like value changes nothing
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSelIndex = 1'b1; cfgData = 8'h08;
    idle();
    writeAndExpect("R2", 16'h0304, 8'h44, 4'h3, 16'h0304);

    curReq = "R5";
    cfgWrite(2, 8'h0F);
    cfgWrite(4, 8'h08);
    for (int i = 0; i < 8; i++) writeAndExpect("R5", 16'h0400 + i, i, 1 << (i % 4), (16'h0400 + i) / 4);
    cfgWrite(2, 8'h0A);
    writeAndExpect("R5", 16'h0005, 8'h55, 4'h2, 16'h0001);
    writeAndExpect("R9", 16'h0006, 8'h66, 4'h0, 0);

    curReq = "R3";
    cfgWrite(2, 8'h0F);
    cfgWrite(4, 8'hF3);
    writeAndExpect("R3", 16'h0777, 8'h77, 4'hF, 16'h0777);
    cfgWrite(4, 8'h0C);
    writeAndExpect("R5", 16'h0013, 8'h13, 4'h8, 16'h0004);

    curReq = "R6";
    cfgWrite(4, 8'h04);
    writeAndExpect("R6", 16'h0020, 8'hA0, 4'h5, 16'h0020);
    writeAndExpect("R6", 16'h0021, 8'hA1, 4'hA, 16'h0020);
    cfgWrite(2, 8'h06);
    writeAndExpect("R6", 16'h0023, 8'hA3, 4'h2, 16'h0022);
    writeAndExpect("R6", 16'h0024, 8'hA4, 4'h4, 16'h0024);

    curReq = "R9";
    cfgWrite(4, 8'h00);
    cfgWrite(2, 8'h00);
    writeAndExpect("R9", 16'h0FFF, 8'hEE, 4'h0, 0);

    curReq = "R7";
    cfgWrite(2, 8'h0F);
    cfgWrite(4, 8'h08);
    for (int i = 0; i < 12; i++) cpuWrite(16'h2000 + i * 3, 8'hC0 + i);
    idle();
    idle();

    curReq = "R8";
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSelIndex = 1'b1; cfgData = 8'h02;
    @(negedge clk);
    cfgSelIndex = 1'b0; cfgData = 8'h01;
    cpuWrEn = 1'b1; cpuAddr = 16'h0002; cpuData = 8'hB2;
    @(negedge clk);
    cfgWrEn = 1'b0; cpuAddr = 16'h0006; cpuData = 8'hB6;
    chk("R8", "old mask still used", int'(planeWe), 4'h4);
    idle();
    chk("R8", "new mask applied", int'(planeWe), 4'h0);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSelIndex = 1'b1; cfgData = 8'h04;
    @(negedge clk);
    cfgSelIndex = 1'b0; cfgData = 8'h00;
    cpuWrEn = 1'b1; cpuAddr = 16'h0010; cpuData = 8'hB0;
    @(negedge clk);
    cfgWrEn = 1'b0;
    chk("R8", "old chain-4 offset", int'(planeAddr), 16'h0004);
    idle();
    chk("R8", "planar offset after change", int'(planeAddr), 16'h0010);

    repeat (3) idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule